// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends parallel words out on one serial data line. The bit timing comes from an external master. A shift clock supplied from outside the chip is brought into the system clock domain through a flop synchroniser. An edge detector turns it into a one-cycle strobe, and each strobe on the selected polarity advances the outgoing frame by one bit. The block never generates a shift clock of its own.

Words arrive on a valid/ready write port and are buffered in two stages: a holding register and a shift register. If the shift register is idle, a word written to the holding register moves across on the next cycle and its first bit appears on the line. If a word is already shifting, a second word waits in the holding register. It moves across only on the active edge that ends the current frame. The holding-empty flag rises on that same cycle and gates a level interrupt. Frames are 8 bits, or 9 bits when the ninth-bit mode is selected. Clearing either enable aborts everything.

Back-pressure rule: `wr_ready` is high only while both enables are set and the holding register is empty. A word transfers on a cycle where `wr_valid` and `wr_ready` are both high. `wr_data` and `wr_bit9` must be held steady while `wr_valid` is high and `wr_ready` is low.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `hold_empty`=1, `shift_empty`=1, `sdo`=1 (idle level), and `irq`=0 while `irq_en`=0.
- R2: A word accepted while the shift register is idle makes `hold_empty` read 0 for exactly one cycle. On the next cycle it is 1 again, `shift_empty` is 0, and `sdo` carries bit 0 of the word.
- R3: Bits leave least significant bit first. Each active edge of `ext_sck` moves `sdo` to the next bit. With `sck_pol`=0 the rising edge is active; with `sck_pol`=1 the falling edge is active. The opposite edge has no effect.
- R4: A word accepted while another word is shifting stays in the holding register. `hold_empty` and `wr_ready` stay 0 through every bit of the current frame.
- R5: On the active edge that ends the current frame, a waiting word moves into the shift register. On that same cycle `hold_empty` goes to 1 and `sdo` shows bit 0 of the new word, with no idle gap.
- R6: With `nine_bit`=1 at load, the frame is 9 bits and bit 8 is `wr_bit9`. With `nine_bit`=0 the frame is 8 bits and `wr_bit9` is ignored.
- R7: `irq` equals `irq_en` AND `hold_empty`.
- R8: While `port_en` or `tx_en` is 0, `wr_ready` is 0 and written words are dropped. Clearing either enable empties both registers on the next cycle, and `sdo` returns to 1.
- R9: When the last bit of a frame has been shifted out and no word is waiting, `shift_empty` goes to 1 on that edge and `sdo` is 1.
- R10: An active edge of `ext_sck` changes `sdo` on the third rising edge of `clk` after it; `ext_sck` must run at no more than a quarter of the `clk` rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | Select 9-bit frames |
| sck_pol | input | 1 | Active shift edge: 0 rising, 1 falling |
| irq_en | input | 1 | Interrupt enable |
| ext_sck | input | 1 | Shift clock from the external master |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Holding register can accept a word |
| wr_data | input | DATA_W | Write data |
| wr_bit9 | input | 1 | Ninth data bit |
| sdo | output | 1 | Serial data out |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Transmit interrupt |

## Verification
A corrupted bit counter shows up as a frame of the wrong length. The next word then begins one edge early or late, and `sdo` differs from the expected bit within one external clock period. A holding register that is wrongly full or empty shows up on `hold_empty` and `wr_ready` on the very next system cycle. A lost word shows up as an idle-high `sdo` where data should be. Synchroniser latency is pinned to an exact number of system cycles, so an extra or missing stage is seen at the first active edge.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam logic LINE_IDLE = 1'b1;

  function automatic int frame_bits(input int data_w, input logic ninth);
    return ninth ? data_w + 1 : data_w;
  endfunction
endpackage

// File: rtl/sstx_edge_sync.sv
module sstx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic pol,
  output logic act_edge
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= sck_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  logic rise, fall;
  always_comb begin
    rise     = chain[STAGES-1] & ~last_q;
    fall     = ~chain[STAGES-1] & last_q;
    act_edge = pol ? fall : rise;
  end
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              put,
  input  logic [WORD_W-1:0] put_word,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (clr) begin
      full <= 1'b0;
    end else if (put) begin
      full <= 1'b1;
      word <= put_word;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sstx_shift.sv
module sstx_shift
  import sstx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ninth,
  input  logic            load,
  input  logic [DATA_W:0] load_word,
  input  logic            adv,
  output logic            busy,
  output logic            last,
  output logic            sdo
);
  localparam int FRM_W = DATA_W + 1;
  localparam int CNT_W = $clog2(FRM_W);

  logic [FRM_W-1:0] sreg;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sreg   <= '1;
      remain <= '0;
    end else if (clr) begin
      busy   <= 1'b0;
      sreg   <= '1;
      remain <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      sreg   <= load_word;
      remain <= CNT_W'(frame_bits(DATA_W, ninth) - 1);
    end else if (adv && busy) begin
      if (remain == '0) begin
        busy <= 1'b0;
        sreg <= '1;
      end else begin
        sreg   <= {LINE_IDLE, sreg[FRM_W-1:1]};
        remain <= remain - 1'b1;
      end
    end
  end

  always_comb begin
    last = busy && (remain == '0);
    sdo  = busy ? sreg[0] : LINE_IDLE;
  end
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sstx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              sck_pol,
  input  logic              irq_en,
  input  logic              ext_sck,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  output logic              sdo,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  localparam int WORD_W = DATA_W + 1;

  logic              on, act_edge, hold_full, sh_busy, sh_last;
  logic              put, load, frame_done;
  logic [WORD_W-1:0] hold_word;

  assign on = port_en & tx_en;

  sstx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(ext_sck), .pol(sck_pol), .act_edge(act_edge)
  );

  always_comb begin
    wr_ready   = on & ~hold_full;
    put        = wr_valid & wr_ready;
    frame_done = act_edge & sh_last;
    load       = on & hold_full & (~sh_busy | frame_done);
  end

  sstx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(~on), .put(put),
    .put_word({wr_bit9, wr_data}), .take(load), .full(hold_full), .word(hold_word)
  );

  sstx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(~on), .ninth(nine_bit), .load(load),
    .load_word(hold_word), .adv(act_edge), .busy(sh_busy), .last(sh_last), .sdo(sdo)
  );

  always_comb begin
    hold_empty  = ~hold_full;
    shift_empty = ~sh_busy;
    irq         = irq_en & hold_empty;
  end
endmodule

// File: rtl/sstx_checker.sv
module sstx_checker (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic tx_en,
  input logic irq_en,
  input logic wr_valid,
  input logic wr_ready,
  input logic sdo,
  input logic hold_empty,
  input logic shift_empty,
  input logic irq
);
  a_r9_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> sdo);

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && tx_en) |=> (hold_empty && shift_empty && sdo));

  a_r8_no_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && tx_en) |-> !wr_ready);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (hold_empty && irq_en));

  a_r4_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !hold_empty);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && shift_empty) |=> shift_empty);
endmodule

bind sync_slave_tx sstx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .irq_en(irq_en),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .sdo(sdo), .hold_empty(hold_empty),
  .shift_empty(shift_empty), .irq(irq)
);

// File: tb/test_sync_slave_tx.sv
module test_sync_slave_tx;
  logic clk = 0, rst_n = 0;
  logic port_en = 0, tx_en = 0, nine_bit = 0, sck_pol = 0, irq_en = 0, ext_sck = 0;
  logic wr_valid = 0, wr_bit9 = 0;
  logic [7:0] wr_data = '0;
  logic wr_ready, sdo, hold_empty, shift_empty, irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sync_slave_tx i_sync_slave_tx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .nine_bit(nine_bit),
    .sck_pol(sck_pol), .irq_en(irq_en), .ext_sck(ext_sck), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_bit9(wr_bit9), .sdo(sdo),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    ext_sck = ~sck_pol;
    repeat (4) @(negedge clk);
    ext_sck = sck_pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d, input logic b9);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = d; wr_bit9 = b9;
    @(negedge clk);
    wr_valid = 0;
  endtask

  function automatic int fbit(input logic [7:0] d, input logic b9, input int k);
    return (k < 8) ? int'(d[k]) : int'(b9);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hold_empty", hold_empty, 1);
    check("R1 shift_empty", shift_empty, 1);
    check("R1 sdo", sdo, 1);
    check("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    port_en = 1; tx_en = 1;
    @(negedge clk);

    for (int nb = 0; nb < 2; nb++)
      for (int pl = 0; pl < 2; pl++)
        for (int p = 0; p < 6; p++) begin
          logic [7:0] a, b;
          logic ba, bb;
          int n;
          a  = 8'(p * 53 + 17 + nb * 90 + pl * 7);
          b  = 8'((p + 3) * 101) ^ 8'h3C;
          ba = p[0]; bb = ~p[0];
          n  = nb ? 9 : 8;
          nine_bit = nb[0]; sck_pol = pl[0]; ext_sck = pl[0]; irq_en = p[1];
          repeat (6) @(negedge clk);
          write_word(a, ba);
          check("R4 hold_empty after accept", hold_empty, 0);
          @(negedge clk);
          check("R2 hold_empty after move", hold_empty, 1);
          check("R2 shift_empty busy", shift_empty, 0);
          check("R7 irq follows empty", irq, int'(p[1]));
          write_word(b, bb);
          check("R4 second word held", hold_empty, 0);
          check("R4 ready low", wr_ready, 0);
          check("R7 irq low when full", irq, 0);
          for (int k = 0; k < n; k++) begin
            check("R3 R6 frame A bit", sdo, fbit(a, ba, k));
            if (k == n - 1) check("R4 held through last bit", hold_empty, 0);
            pulse();
          end
          check("R5 empty rises at frame end", hold_empty, 1);
          check("R5 shift busy with next", shift_empty, 0);
          for (int k = 0; k < n; k++) begin
            check("R5 R6 frame B bit", sdo, fbit(b, bb, k));
            pulse();
          end
          check("R9 shift_empty", shift_empty, 1);
          check("R9 sdo idle", sdo, 1);
        end

    // R10 edge latency
    nine_bit = 0; sck_pol = 0; ext_sck = 0; irq_en = 0;
    repeat (6) @(negedge clk);
    write_word(8'h02, 1'b0);
    @(negedge clk);
    check("R10 bit0 before edge", sdo, 0);
    ext_sck = 1;
    @(negedge clk); @(negedge clk);
    check("R10 no change after two clocks", sdo, 0);
    @(negedge clk);
    check("R10 change on third clock", sdo, 1);
    ext_sck = 0;
    repeat (4) @(negedge clk);
    check("R3 inactive edge ignored", sdo, 1);

    // R8 abort
    tx_en = 0;
    @(negedge clk);
    check("R8 abort hold_empty", hold_empty, 1);
    check("R8 abort shift_empty", shift_empty, 1);
    check("R8 abort sdo", sdo, 1);
    check("R8 ready low", wr_ready, 0);
    wr_valid = 1; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    wr_valid = 0; tx_en = 1;
    @(negedge clk);
    check("R8 dropped write shift", shift_empty, 1);
    check("R8 dropped write hold", hold_empty, 1);
    port_en = 0;
    @(negedge clk);
    check("R8 port disable ready", wr_ready, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule